// File: doc/BRIEF.md
# Display Bias Power-Up Sequencer

This block orders the enables of the supply rails that bias a display panel. Once the input supply crosses its undervoltage threshold, it brings up the logic rail first. It then releases the timing-controller reset and starts the source rail. The negative gate rail follows, and after it the positive gate rail. Last, it opens the gate-shaping path so that the shaping output follows the flicker input. Some steps wait a programmed number of clock cycles. Others wait for a ramp-done flag from the rail. One step waits a programmed time after a rail has *started* ramping rather than after it has finished.

The panel reset output has its own branch, driven only by the supply-detect comparator and its own delay. The LED driver enable is the AND of the source-rail-done flag and the enable pin. The pin has no effect until the whole start-up sequence has completed. If the supply drops below the undervoltage threshold, the sequencer turns every rail enable off, pulls the timing-controller reset low and starts over. Each delay value is a configuration input, loaded into a down counter on entry to its step.

Top module: `disp_bias_seq`

## Requirements
- R1: After reset all eight outputs are 0.
- R2: `logic_en` rises N1+1 clock edges after the first edge at which `vin_uv_ok` is sampled 1, where N1 = `cfg_dly1`.
- R3: `tcon_rst_n` rises NT+1 edges after the first edge at which `logic_done` is sampled 1 while `logic_en` is 1, where NT = `cfg_trst`.
- R4: `src_en` rises N2+1 edges after `tcon_rst_n` rises, where N2 = `cfg_dly2`.
- R5: `neg_en` rises N3+1 edges after `src_en` rises, where N3 = `cfg_dly3`. The count starts when the source rail starts, not when it finishes.
- R6: `pos_en` rises at the first edge at which `neg_done` is sampled 1 while `neg_en` is 1.
- R7: `gshape_out` stays 0 until N4+1 edges after the first edge at which `pos_done` is sampled 1 while `pos_en` is 1, where N4 = `cfg_dly4`. From then on it equals `flk_in` combinationally.
- R8: `panel_rst_n` rises N6+1 edges after the first edge at which `vin_det_ok` is sampled 1, where N6 = `cfg_dly6`. It falls at the first edge at which `vin_det_ok` is sampled 0. It does not depend on `vin_uv_ok`.
- R9: `led_drv_en` is 0 until the sequence reaches the step of R7. From then on it equals `src_done` AND `led_en_pin`.
- R10: At the first edge at which `vin_uv_ok` is sampled 0, these outputs all go to 0: `logic_en`, `tcon_rst_n`, `src_en`, `neg_en`, `pos_en`, `gshape_out` and `led_drv_en`. This happens in any step, including part-way through a delay. When `vin_uv_ok` returns, the sequence restarts at R2.
- R11: While `vin_uv_ok` stays 1, a rail enable or `tcon_rst_n` that has risen does not fall, and each one rises only after the one before it in the order of R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_uv_ok | input | 1 | Input supply above the undervoltage threshold |
| vin_det_ok | input | 1 | Input supply above the detect threshold |
| logic_done | input | 1 | Logic rail finished ramping |
| src_done | input | 1 | Source rail finished ramping |
| neg_done | input | 1 | Negative gate rail finished ramping |
| pos_done | input | 1 | Positive gate rail finished ramping |
| flk_in | input | 1 | Flicker input passed to the gate-shaping output |
| led_en_pin | input | 1 | LED driver enable pin |
| cfg_dly1 | input | DLY_W | Cycles before the logic rail starts |
| cfg_trst | input | DLY_W | Cycles from logic rail done to reset release |
| cfg_dly2 | input | DLY_W | Cycles from reset release to source rail start |
| cfg_dly3 | input | DLY_W | Cycles from source rail start to negative rail start |
| cfg_dly4 | input | DLY_W | Cycles from positive rail done to gate-shaping enable |
| cfg_dly6 | input | DLY_W | Cycles from supply detect to panel reset release |
| logic_en | output | 1 | Logic rail enable |
| tcon_rst_n | output | 1 | Timing-controller reset, active low |
| src_en | output | 1 | Source rail enable |
| neg_en | output | 1 | Negative gate rail enable |
| pos_en | output | 1 | Positive gate rail enable |
| gshape_out | output | 1 | Gate-shaping output |
| panel_rst_n | output | 1 | Panel reset, active low |
| led_drv_en | output | 1 | LED driver enable |

## Verification
All outputs are decoded directly from the sequencer state, so a wrong state or a wrong counter value shows up at the ports on the same clock edge. It appears as an enable edge in the wrong cycle, or an edge that should not occur at all. The bench predicts the exact cycle of every rising and falling output edge from the programmed delays and the ramp-done stimulus. Any early, late, missing or extra edge is therefore reported in the cycle where it happens. The delay values under test include zero, the case in which a counter off by one would first show.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  // The order of the states matters: each output is on from its step onwards
  typedef enum logic [3:0] {
    SQ_OFF   = 4'd0,
    SQ_WAIT1 = 4'd1,
    SQ_LOGIC = 4'd2,
    SQ_TRST  = 4'd3,
    SQ_WAIT2 = 4'd4,
    SQ_WAIT3 = 4'd5,
    SQ_NEGW  = 4'd6,
    SQ_POSW  = 4'd7,
    SQ_WAIT4 = 4'd8,
    SQ_RUN   = 4'd9
  } seq_st_e;

endpackage

// File: rtl/dseq_rst_sync.sv
module dseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dseq_dly_cnt.sv
module dseq_dly_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  assign zero   = (cnt_q == '0);
  assign cnt_ce = ld | ~zero;

  always_comb begin
    if (ld) cnt_d = ld_val;
    else    cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // Once expired and not reloaded, the counter must not wrap around
  AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !ld) |=> zero); // R2
endmodule

// File: rtl/dseq_panel_rst.sv
module dseq_panel_rst #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         det_ok,
  input  logic [W-1:0] dly,
  output logic         prst_n
);
  logic armed_q, prst_q, prst_d, cnt_zero, cnt_ld;

  // Keep the counter loaded while idle, so it holds the delay on the arming edge
  assign cnt_ld = ~armed_q;
  assign prst_d = det_ok & armed_q & (prst_q | cnt_zero);

  dseq_dly_cnt #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (cnt_ld),
    .ld_val (dly),
    .zero   (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prst_q  <= 1'b0;
    end else begin
      armed_q <= det_ok;
      prst_q  <= prst_d;
    end
  end

  assign prst_n = prst_q;

  AST_PRST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !det_ok |=> !prst_n); // R8
  AST_PRST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prst_n) |-> $past(armed_q) && $past(det_ok)); // R8
endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
  import disp_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         uv_ok,
  input  logic         logic_done,
  input  logic         neg_done,
  input  logic         pos_done,
  input  logic [W-1:0] dly1,
  input  logic [W-1:0] trst,
  input  logic [W-1:0] dly2,
  input  logic [W-1:0] dly3,
  input  logic [W-1:0] dly4,
  output logic         logic_on,
  output logic         tcon_rel,
  output logic         src_on,
  output logic         neg_on,
  output logic         pos_on,
  output logic         seq_done
);
  seq_st_e      st_q, st_d;
  logic         cnt_ld, cnt_zero;
  logic [W-1:0] cnt_val;

  // One counter serves every timed step, since the steps never overlap
  dseq_dly_cnt #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (cnt_ld),
    .ld_val (cnt_val),
    .zero   (cnt_zero)
  );

  always_comb begin
    st_d    = st_q;
    cnt_ld  = 1'b0;
    cnt_val = '0;
    unique case (st_q)
      SQ_OFF:   if (uv_ok)      begin st_d = SQ_WAIT1; cnt_ld = 1'b1; cnt_val = dly1; end
      SQ_WAIT1: if (cnt_zero)   st_d = SQ_LOGIC;
      SQ_LOGIC: if (logic_done) begin st_d = SQ_TRST;  cnt_ld = 1'b1; cnt_val = trst; end
      SQ_TRST:  if (cnt_zero)   begin st_d = SQ_WAIT2; cnt_ld = 1'b1; cnt_val = dly2; end
      SQ_WAIT2: if (cnt_zero)   begin st_d = SQ_WAIT3; cnt_ld = 1'b1; cnt_val = dly3; end
      SQ_WAIT3: if (cnt_zero)   st_d = SQ_NEGW;
      SQ_NEGW:  if (neg_done)   st_d = SQ_POSW;
      SQ_POSW:  if (pos_done)   begin st_d = SQ_WAIT4; cnt_ld = 1'b1; cnt_val = dly4; end
      SQ_WAIT4: if (cnt_zero)   st_d = SQ_RUN;
      SQ_RUN:   st_d = SQ_RUN;
      default:  st_d = SQ_OFF;
    endcase
    // Loss of supply overrides every step
    if (!uv_ok) begin
      st_d   = SQ_OFF;
      cnt_ld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_OFF;
    else        st_q <= st_d;
  end

  assign logic_on = (st_q >= SQ_LOGIC);
  assign tcon_rel = (st_q >= SQ_WAIT2);
  assign src_on   = (st_q >= SQ_WAIT3);
  assign neg_on   = (st_q >= SQ_NEGW);
  assign pos_on   = (st_q >= SQ_POSW);
  assign seq_done = (st_q == SQ_RUN);

  AST_TCON_AFTER_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcon_rel) |-> $past(logic_on)); // R3
  AST_SRC_AFTER_TCON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_on) |-> $past(tcon_rel)); // R4
  AST_NEG_AFTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(neg_on) |-> $past(src_on)); // R5
  AST_POS_ON_NEG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_on) |-> $past(neg_done) && $past(neg_on)); // R6
  AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_ok && logic_on) |=> logic_on); // R11
endmodule

// File: rtl/disp_bias_seq.sv
module disp_bias_seq #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin_uv_ok,
  input  logic             vin_det_ok,
  input  logic             logic_done,
  input  logic             src_done,
  input  logic             neg_done,
  input  logic             pos_done,
  input  logic             flk_in,
  input  logic             led_en_pin,
  input  logic [DLY_W-1:0] cfg_dly1,
  input  logic [DLY_W-1:0] cfg_trst,
  input  logic [DLY_W-1:0] cfg_dly2,
  input  logic [DLY_W-1:0] cfg_dly3,
  input  logic [DLY_W-1:0] cfg_dly4,
  input  logic [DLY_W-1:0] cfg_dly6,
  output logic             logic_en,
  output logic             tcon_rst_n,
  output logic             src_en,
  output logic             neg_en,
  output logic             pos_en,
  output logic             gshape_out,
  output logic             panel_rst_n,
  output logic             led_drv_en
);
  logic rst_i_n, seq_done;

  dseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dseq_fsm #(.W(DLY_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .uv_ok      (vin_uv_ok),
    .logic_done (logic_done),
    .neg_done   (neg_done),
    .pos_done   (pos_done),
    .dly1       (cfg_dly1),
    .trst       (cfg_trst),
    .dly2       (cfg_dly2),
    .dly3       (cfg_dly3),
    .dly4       (cfg_dly4),
    .logic_on   (logic_en),
    .tcon_rel   (tcon_rst_n),
    .src_on     (src_en),
    .neg_on     (neg_en),
    .pos_on     (pos_en),
    .seq_done   (seq_done)
  );

  dseq_panel_rst #(.W(DLY_W)) u_prst (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .det_ok (vin_det_ok),
    .dly    (cfg_dly6),
    .prst_n (panel_rst_n)
  );

  assign gshape_out = seq_done & flk_in;
  assign led_drv_en = seq_done & src_done & led_en_pin;

  AST_UV_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_i_n)
    !vin_uv_ok |=> !logic_en && !tcon_rst_n && !src_en && !neg_en && !pos_en
                   && !gshape_out && !led_drv_en); // R10
  AST_SHAPE_NEEDS_POS: assert property (@(posedge clk) disable iff (!rst_i_n)
    gshape_out |-> pos_en && neg_en); // R7
  AST_LED_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    led_drv_en |-> pos_en && led_en_pin && src_done); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> !logic_en && !src_en && !panel_rst_n && !led_drv_en); // R1
endmodule

// File: tb/disp_bias_seq_bench.sv
module disp_bias_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic vin_uv_ok, vin_det_ok, logic_done, src_done, neg_done, pos_done;
  logic flk_in, led_en_pin;
  logic [DW-1:0] cfg_dly1, cfg_trst, cfg_dly2, cfg_dly3, cfg_dly4, cfg_dly6;
  logic logic_en, tcon_rst_n, src_en, neg_en, pos_en, gshape_out, panel_rst_n, led_drv_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct packed {
    logic [7:0]  bitn;
    logic        lvl;
    logic [31:0] at;
    logic [7:0]  req;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  disp_bias_seq #(.DLY_W(DW)) u_disp_bias_seq (
    .clk(clk), .rst_n(rst_n), .vin_uv_ok(vin_uv_ok), .vin_det_ok(vin_det_ok),
    .logic_done(logic_done), .src_done(src_done), .neg_done(neg_done), .pos_done(pos_done),
    .flk_in(flk_in), .led_en_pin(led_en_pin),
    .cfg_dly1(cfg_dly1), .cfg_trst(cfg_trst), .cfg_dly2(cfg_dly2), .cfg_dly3(cfg_dly3),
    .cfg_dly4(cfg_dly4), .cfg_dly6(cfg_dly6),
    .logic_en(logic_en), .tcon_rst_n(tcon_rst_n), .src_en(src_en), .neg_en(neg_en),
    .pos_en(pos_en), .gshape_out(gshape_out), .panel_rst_n(panel_rst_n), .led_drv_en(led_drv_en)
  );

  // bit 0 logic_en, 1 tcon_rst_n, 2 src_en, 3 neg_en, 4 pos_en, 5 panel_rst_n, 6 gshape_out, 7 led_drv_en
  wire [7:0] obs = {led_drv_en, gshape_out, panel_rst_n, pos_en, neg_en, src_en, tcon_rst_n, logic_en};
  logic [7:0] prev_obs = 8'h00;

  function automatic int req_of(input int b);
    case (b)
      0: return 2; 1: return 3; 2: return 4; 3: return 5;
      4: return 6; 5: return 8; 6: return 7; default: return 9;
    endcase
  endfunction

  task automatic push(input int b, input int lvl, input int at, input int req);
    exp_t e;
    e.bitn = 8'(b); e.lvl = lvl[0]; e.at = 32'(at); e.req = 8'(req);
    expq.push_back(e);
  endtask

  task automatic at_cyc(input int c);
    while (cyc < c) begin
      @(posedge clk);
      #2;
    end
  endtask

  // Monitor: every output edge must match the next expected item
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 8; i++) begin
        if (obs[i] != prev_obs[i]) begin
          checks++;
          if (expq.size() == 0) begin
            // R11: no edge may occur that the requirements do not call for
            errors++;
            $display("FAIL R%0d unexpected edge on bit %0d: got level %0b at cycle %0d, expected no change",
                     req_of(i), i, obs[i], cyc);
          end else begin
            exp_t e;
            e = expq.pop_front();
            if (int'(e.bitn) != i || e.lvl != obs[i] || int'(e.at) != cyc) begin
              errors++;
              $display("FAIL R%0d got bit %0d level %0b at cycle %0d, expected bit %0d level %0b at cycle %0d",
                       e.req, i, obs[i], cyc, e.bitn, e.lvl, e.at);
            end
          end
        end
      end
      prev_obs = obs;
    end
  end

  // One power-up run; abort_src drops the supply while only the source rail is on
  task automatic run_seq(input int d1, input int dt, input int d2, input int d3, input int d4,
                         input bit abort_src);
    int t, e1, e2, e3, e4, e5, e6;
    cfg_dly1 = DW'(d1); cfg_trst = DW'(dt); cfg_dly2 = DW'(d2);
    cfg_dly3 = DW'(d3); cfg_dly4 = DW'(d4);
    flk_in = 1'b1;
    led_en_pin = 1'b1;                     // R9: pin high early must have no effect
    t = cyc;
    e1 = t + d1 + 2;
    push(0, 1, e1, 2);                     // R2
    vin_uv_ok = 1'b1;
    at_cyc(e1 + 2);
    e2 = e1 + 3 + dt + 1;
    push(1, 1, e2, 3);                     // R3
    e3 = e2 + d2 + 1;
    push(2, 1, e3, 4);                     // R4
    logic_done = 1'b1;
    if (abort_src) begin
      at_cyc(e3 + 1);
      push(0, 0, e3 + 2, 10);              // R10 shutdown mid-delay
      push(1, 0, e3 + 2, 10);
      push(2, 0, e3 + 2, 10);
      vin_uv_ok = 1'b0;
      logic_done = 1'b0;
      at_cyc(e3 + 6);
      return;
    end
    e4 = e3 + d3 + 1;
    push(3, 1, e4, 5);                     // R5
    at_cyc(e3 + 2);
    src_done = 1'b1;
    at_cyc(e4 + 3);
    e5 = e4 + 4;
    push(4, 1, e5, 6);                     // R6
    neg_done = 1'b1;
    at_cyc(e5 + 2);
    e6 = e5 + 3 + d4 + 1;
    push(6, 1, e6, 7);                     // R7
    push(7, 1, e6, 9);                     // R9
    pos_done = 1'b1;
    at_cyc(e6 + 3);
    push(6, 0, e6 + 3, 7);                 // R7 follows flicker
    flk_in = 1'b0;
    at_cyc(e6 + 5);
    push(6, 1, e6 + 5, 7);                 // R7
    flk_in = 1'b1;
    at_cyc(e6 + 7);
    push(7, 0, e6 + 7, 9);                 // R9 pin now takes effect
    led_en_pin = 1'b0;
    at_cyc(e6 + 10);
    for (int b = 0; b < 7; b++)
      if (b != 5) push(b, 0, e6 + 11, 10); // R10, panel reset (R8) stays high
    vin_uv_ok = 1'b0;
    logic_done = 1'b0; src_done = 1'b0; neg_done = 1'b0; pos_done = 1'b0;
    at_cyc(e6 + 15);
  endtask

  initial begin
    int t;
    rst_n = 1'b0;
    vin_uv_ok = 0; vin_det_ok = 0; logic_done = 0; src_done = 0; neg_done = 0; pos_done = 0;
    flk_in = 0; led_en_pin = 0;
    cfg_dly1 = '0; cfg_trst = '0; cfg_dly2 = '0; cfg_dly3 = '0; cfg_dly4 = '0; cfg_dly6 = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    checks++;
    if (obs !== 8'h00) begin                // R1
      errors++;
      $display("FAIL R1 outputs after reset: got %b, expected %b", obs, 8'h00);
    end

    // R8: panel reset branch, with the supply-good input low throughout
    cfg_dly6 = DW'(4);
    t = cyc;
    push(5, 1, t + 6, 8);
    vin_det_ok = 1'b1;
    at_cyc(t + 12);
    push(5, 0, cyc + 1, 8);
    vin_det_ok = 1'b0;
    at_cyc(cyc + 3);
    cfg_dly6 = '0;                         // R8 zero delay
    t = cyc;
    push(5, 1, t + 2, 8);
    vin_det_ok = 1'b1;
    at_cyc(t + 5);

    run_seq(3, 2, 4, 3, 5, 1'b0);          // R2..R7, R9, R10 with nonzero delays
    run_seq(3, 2, 4, 3, 5, 1'b1);          // R10 abort part-way
    run_seq(0, 0, 0, 0, 0, 1'b0);          // zero delays, restart after abort

    at_cyc(cyc + 10);
    checks++;
    if (expq.size() != 0) begin             // R11 every predicted edge occurred
      errors++;
      $display("FAIL R11 pending expected edges: got %0d, expected 0", expq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got no completion, expected end of test");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule